// File: doc/BRIEF.md
# Configurable-Convention LIFO Stack

This block is a synchronous last-in-first-out store built from an internal register array. It has one stack pointer. A parameter fixes how that pointer is used. It can point at the next free slot or at the newest entry, and the stack can grow toward lower or higher addresses.

A single enable input gates every operation. A single direction input chooses between storing the write word and retrieving the newest stored word. The retrieved word is registered. Full and empty flags come from a separate occupancy count, so they behave the same way under every convention. A one-cycle error pulse reports any request that was refused.

From the ports, all four conventions behave as the same stack. The convention only changes the pointer's start value, which slot is addressed relative to the pointer, and the direction of growth.

Top module: `lifo_stack`

## Requirements
- R1: With `en_i`=1 and `push_i`=1 and the stack not full, `wdata_i` is stored. With `en_i`=1 and `push_i`=0 and the stack not empty, the most recently stored word that has not yet been retrieved appears on `rdata_o` after that clock edge.
- R2: With `en_i`=0, no store or retrieve happens whatever `push_i` is: `rdata_o`, `full_o` and `empty_o` keep their values and `err_o` stays 0.
- R3: A store request while `full_o`=1 is refused. Contents and flags are unchanged, and `err_o` is 1 in the next cycle.
- R4: A retrieve request while `empty_o`=1 is refused. `rdata_o` and the flags are unchanged, and `err_o` is 1 in the next cycle.
- R5: `full_o` is 1 exactly when DEPTH words are held, and `empty_o` is 1 exactly when none are held. The two are never 1 together.
- R6: `rdata_o` changes only after an accepted retrieve; it holds its value across stores and idle cycles.
- R7: While `rst_ni`=0 (asynchronous, active low), `empty_o`=1, `full_o`=0, `err_o`=0 and `rdata_o`=0, and the stack is emptied.
- R8: `MODE` selects one of four conventions: EMPTY_DESC (pointer starts at DEPTH-1 and addresses the next free slot), EMPTY_ASC (starts at 0, next free slot), FULL_DESC (starts at DEPTH, addresses the newest entry) and FULL_ASC (starts at -1, newest entry). Every convention gives identical port behaviour.
- R9: `err_o` is 1 only in the cycle after a refused request, and is 0 after every accepted request or idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Operation enable |
| push_i | input | 1 | 1 = store request, 0 = retrieve request |
| wdata_i | input | DATA_W | Word to store |
| rdata_o | output | DATA_W | Last retrieved word, registered |
| full_o | output | 1 | Stack holds DEPTH words |
| empty_o | output | 1 | Stack holds no words |
| err_o | output | 1 | One-cycle pulse after a refused request |

## Verification
All four conventions are instantiated side by side and driven with the same sequence, so an addressing slip in any one of them shows up as a wrong retrieved word. Interleaved stores and retrieves with distinct words separate true last-in-first-out order from queue order and from stale reads. Disabled requests of both directions, placed between operations, show that enable really gates activity and that `rdata_o` holds. Filling to capacity, one store past it, draining to zero and one retrieve past that test both flag edges and the error pulse. A reset in the middle of a run shows that the count, not only the flags, returns to empty.

// File: rtl/lifo_pkg.sv
package lifo_pkg;
  typedef enum logic [1:0] {
    EMPTY_DESC = 2'd0,
    EMPTY_ASC  = 2'd1,
    FULL_DESC  = 2'd2,
    FULL_ASC   = 2'd3
  } stack_mode_e;

  function automatic bit mode_ascending(stack_mode_e m);
    return (m == EMPTY_ASC) || (m == FULL_ASC);
  endfunction

  function automatic bit mode_points_free(stack_mode_e m);
    return (m == EMPTY_DESC) || (m == EMPTY_ASC);
  endfunction
endpackage

// File: rtl/lifo_ptr.sv
module lifo_ptr #(
  parameter int                   DEPTH = 256,
  parameter lifo_pkg::stack_mode_e MODE = lifo_pkg::EMPTY_DESC,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  output logic [AW-1:0] wr_addr_o,
  output logic [AW-1:0] rd_addr_o,
  output logic [CW-1:0] count_o
);
  localparam int PW = AW + 1;
  localparam bit ASC  = lifo_pkg::mode_ascending(MODE);
  localparam bit FREE = lifo_pkg::mode_points_free(MODE);
  localparam logic [PW-1:0] STEP = ASC ? PW'(1) : {PW{1'b1}};
  localparam logic [PW-1:0] PTR_RST =
      ASC ? (FREE ? PW'(0) : {PW{1'b1}})
          : (FREE ? PW'(DEPTH - 1) : PW'(DEPTH));

  logic [PW-1:0] ptr_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= PTR_RST;
      cnt_q <= '0;
    end else if (push_i) begin
      ptr_q <= ptr_q + STEP;
      cnt_q <= cnt_q + CW'(1);
    end else if (pop_i) begin
      ptr_q <= ptr_q - STEP;
      cnt_q <= cnt_q - CW'(1);
    end
  end

  // free-slot pointers write in place; newest-entry pointers pre-step
  generate
    if (FREE) begin : g_free
      assign wr_addr_o = AW'(ptr_q);
      assign rd_addr_o = AW'(ptr_q - STEP);
    end else begin : g_newest
      assign wr_addr_o = AW'(ptr_q + STEP);
      assign rd_addr_o = AW'(ptr_q);
    end
  endgenerate

  assign count_o = cnt_q;
endmodule

// File: rtl/lifo_mem.sv
module lifo_mem #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              re_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/lifo_stack.sv
module lifo_stack #(
  parameter int                    DATA_W = 16,
  parameter int                    DEPTH  = 256,
  parameter lifo_pkg::stack_mode_e MODE   = lifo_pkg::EMPTY_DESC
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              push_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              full_o,
  output logic              empty_o,
  output logic              err_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic          push_ok, pop_ok, refused;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [CW-1:0] count;

  assign push_ok = en_i &  push_i & !full_o;
  assign pop_ok  = en_i & !push_i & !empty_o;
  assign refused = en_i & (push_i ? full_o : empty_o);

  lifo_ptr #(.DEPTH(DEPTH), .MODE(MODE)) u_ptr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .push_i   (push_ok),
    .pop_i    (pop_ok),
    .wr_addr_o(wr_addr),
    .rd_addr_o(rd_addr),
    .count_o  (count)
  );

  lifo_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (push_ok),
    .waddr_i(wr_addr),
    .wdata_i(wdata_i),
    .re_i   (pop_ok),
    .raddr_i(rd_addr),
    .rdata_o(rdata_o)
  );

  assign full_o  = (count == CW'(DEPTH));
  assign empty_o = (count == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_o <= 1'b0;
    else         err_o <= refused;
  end
endmodule

// File: rtl/lifo_stack_chk.sv
module lifo_stack_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic              push_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              full_o,
  input logic              empty_o,
  input logic              err_o
);
  p_flags_exclusive_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(full_o && empty_o));

  p_disabled_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(rdata_o) && $stable(full_o) && $stable(empty_o) && !err_o);

  p_push_when_full_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && push_i && full_o |=> err_o && full_o);

  p_pop_when_empty_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !push_i && empty_o |=> err_o && empty_o && $stable(rdata_o));

  p_rdata_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(en_i && !push_i) |=> $stable(rdata_o));

  p_err_only_refused_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(en_i && (push_i ? full_o : empty_o)) |=> !err_o);
endmodule

bind lifo_stack lifo_stack_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .en_i   (en_i),
  .push_i (push_i),
  .rdata_o(rdata_o),
  .full_o (full_o),
  .empty_o(empty_o),
  .err_o  (err_o)
);

// File: tb/lifo_stack_tb.sv
module lifo_stack_tb;
  localparam int DW = 16;
  localparam int DP = 4;
  localparam int NM = 4;
  localparam int NV = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic en = 1'b0;
  logic push = 1'b0;
  logic [DW-1:0] wdata = '0;

  logic [DW-1:0] rd_w [NM];
  logic          full_w [NM];
  logic          empty_w [NM];
  logic          err_w [NM];

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  for (genvar m = 0; m < NM; m++) begin : g_mode
    lifo_stack #(.DATA_W(DW), .DEPTH(DP), .MODE(lifo_pkg::stack_mode_e'(m))) u_dut (
      .clk_i  (clk),
      .rst_ni (rst_ni),
      .en_i   (en),
      .push_i (push),
      .wdata_i(wdata),
      .rdata_o(rd_w[m]),
      .full_o (full_w[m]),
      .empty_o(empty_w[m]),
      .err_o  (err_w[m])
    );
  end

  // {en, push, wdata, exp_rdata, exp_full, exp_empty, exp_err}
  localparam logic [36:0] VEC [NV] = '{
    {1'b1, 1'b1, 16'h1111, 16'h0000, 1'b0, 1'b0, 1'b0},
    {1'b1, 1'b1, 16'h2222, 16'h0000, 1'b0, 1'b0, 1'b0},
    {1'b0, 1'b1, 16'h9999, 16'h0000, 1'b0, 1'b0, 1'b0},
    {1'b1, 1'b0, 16'h0000, 16'h2222, 1'b0, 1'b0, 1'b0},
    {1'b1, 1'b1, 16'h3333, 16'h2222, 1'b0, 1'b0, 1'b0},
    {1'b1, 1'b1, 16'h4444, 16'h2222, 1'b0, 1'b0, 1'b0},
    {1'b1, 1'b1, 16'h5555, 16'h2222, 1'b1, 1'b0, 1'b0},
    {1'b1, 1'b1, 16'h6666, 16'h2222, 1'b1, 1'b0, 1'b1},
    {1'b0, 1'b0, 16'h0000, 16'h2222, 1'b1, 1'b0, 1'b0},
    {1'b1, 1'b0, 16'h0000, 16'h5555, 1'b0, 1'b0, 1'b0},
    {1'b1, 1'b0, 16'h0000, 16'h4444, 1'b0, 1'b0, 1'b0},
    {1'b1, 1'b0, 16'h0000, 16'h3333, 1'b0, 1'b0, 1'b0},
    {1'b1, 1'b0, 16'h0000, 16'h1111, 1'b0, 1'b1, 1'b0},
    {1'b1, 1'b0, 16'h0000, 16'h1111, 1'b0, 1'b1, 1'b1},
    {1'b1, 1'b1, 16'hABCD, 16'h1111, 1'b0, 1'b0, 1'b0},
    {1'b1, 1'b0, 16'h0000, 16'hABCD, 1'b0, 1'b1, 1'b0}
  };

  task automatic chk(input string req, input logic [DW-1:0] erd,
                     input logic ef, input logic ee, input logic eerr);
    for (int m = 0; m < NM; m++) begin
      checks++;
      if (rd_w[m] !== erd || full_w[m] !== ef || empty_w[m] !== ee || err_w[m] !== eerr) begin
        errors++;
        $display("FAIL %s mode %0d: rdata=%h full=%b empty=%b err=%b expected rdata=%h full=%b empty=%b err=%b",
                 req, m, rd_w[m], full_w[m], empty_w[m], err_w[m], erd, ef, ee, eerr);
      end
    end
  endtask

  task automatic step(input logic e, input logic p, input logic [DW-1:0] d);
    en = e; push = p; wdata = d;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++;
        $display("FAIL watchdog: cycles=%0d expected below 100000", cycles);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    logic [DW-1:0] model [DP];
    repeat (3) @(negedge clk);
    chk("R7 reset state", 16'h0000, 1'b0, 1'b1, 1'b0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R7 after release", 16'h0000, 1'b0, 1'b1, 1'b0);

    // table walk: R1 order, R2 disabled, R3/R4 refusals, R5 flags, R6 hold, R8 modes, R9 pulse
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][36], VEC[i][35], VEC[i][34:19]);
      chk($sformatf("R1/R8 vector %0d", i), VEC[i][18:3], VEC[i][2], VEC[i][1], VEC[i][0]);
    end

    // R5 fill and drain with computed words, R1 reverse order
    for (int i = 0; i < DP; i++) begin
      model[i] = DW'(i * 16'h1357 + 16'h00A5);
      step(1'b1, 1'b1, model[i]);
      chk("R5 fill", 16'hABCD, i == DP - 1, 1'b0, 1'b0);
    end
    step(1'b0, 1'b0, 16'h0000);
    chk("R2 idle while full", 16'hABCD, 1'b1, 1'b0, 1'b0);
    for (int i = DP - 1; i >= 0; i--) begin
      step(1'b1, 1'b0, 16'h0000);
      chk("R1 drain order", model[i], 1'b0, i == 0, 1'b0);
    end
    step(1'b1, 1'b0, 16'h0000);
    chk("R4 pop past empty", model[0], 1'b0, 1'b1, 1'b1);
    step(1'b0, 1'b0, 16'h0000);
    chk("R9 pulse ends", model[0], 1'b0, 1'b1, 1'b0);

    // R7 reset mid-run clears occupancy
    step(1'b1, 1'b1, 16'h7777);
    step(1'b1, 1'b1, 16'h8888);
    en = 1'b0;
    rst_ni = 1'b0;
    #1;
    chk("R7 async reset", 16'h0000, 1'b0, 1'b1, 1'b0);
    @(negedge clk);
    rst_ni = 1'b1;
    step(1'b1, 1'b0, 16'h0000);
    chk("R7 R4 empty after reset", 16'h0000, 1'b0, 1'b1, 1'b1);
    step(1'b1, 1'b1, 16'h0F0F);
    step(1'b1, 1'b0, 16'h0000);
    chk("R8 reuse after reset", 16'h0F0F, 1'b0, 1'b1, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule